// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block paces the clock line of an I2C master. It keeps three counts, all measured in source-clock cycles: one for the SCL high phase, one for the SCL low phase, and one for the start hold. The start hold is the time SDA stays low after a start condition, before SCL first falls. Each phase count is 32 bits wide. Software loads a count in two 16-bit halves: one configuration word carries the lower halves of both phase counts, and a second word carries the upper halves. A third word carries the start-hold count.

The reset values come from two parameters, the source frequency and the SCL frequency. The prescale is the source rate divided by four times the SCL rate, minus one. The high count is four fifths of the prescale and the low count is six fifths, which gives a 40/60 high/low split. The start hold is 4 us for standard rate and 0.6 us for fast rate. While idle, the generator leaves SCL released high. A start request launches the start hold, then alternating low and high phases, until a stop request is seen at the end of a high phase. A byte engine follows four strobes: SCL level, SDA hold-low, the single cycle in which SDA may change, and the SDA sample point.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, scl_o is 1 and the other three outputs are 0. The counts reset to values derived from SRC_HZ and SCL_HZ. At 26 MHz and 400 kHz these are high 12, low 18 and hold 15.
- R2: A write with cfg_sel = 0 puts cfg_wdata[31:16] into bits 15:0 of the high count and cfg_wdata[15:0] into bits 15:0 of the low count. The upper halves of both counts are left unchanged.
- R3: A write with cfg_sel = 1 puts cfg_wdata[31:16] into bits 31:16 of the high count and cfg_wdata[15:0] into bits 31:16 of the low count. A write with cfg_sel = 3 changes nothing.
- R4: When start_req is 1 in an idle cycle, the start hold begins in the next cycle. It lasts exactly the hold count (the value written with cfg_sel = 2), with sda_hold_o = 1 and scl_o = 1.
- R5: Each low phase lasts exactly the low count with scl_o = 0. sda_change_o is 1 only in the first cycle of each low phase.
- R6: Each high phase lasts exactly the high count with scl_o = 1. sda_sample_o is 1 only in the cycle with zero-based index floor(high/2) of that phase.
- R7: If stop_req is 1 in the last cycle of a high phase, the generator goes idle with SCL high. Otherwise a low phase follows.
- R8: start_req has no effect outside the idle state.
- R9: A count of 0 is treated as a one-cycle phase.
- R10: A phase takes its length when it begins. A write made during a phase only affects phases that begin later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Selects the word written: 0 lower halves, 1 upper halves, 2 start hold |
| cfg_wdata | input | 32 | Configuration write data |
| start_req | input | 1 | Start request, taken only when idle |
| stop_req | input | 1 | Stop request, checked in the last cycle of a high phase |
| scl_o | output | 1 | SCL level (1 = released high) |
| sda_hold_o | output | 1 | Hold SDA low for the start hold |
| sda_change_o | output | 1 | SDA may change this cycle |
| sda_sample_o | output | 1 | Sample SDA this cycle |

## Verification
The bench builds the block with SRC_HZ = 26 MHz and SCL_HZ = 400 kHz. With these values the reset counts are small (12, 18 and 15 cycles), so the derived fast-rate defaults, including the start-hold branch, can be checked over full bit periods right after reset. Written counts down to zero cover the one-cycle phase case. One high count with a nonzero upper half (65538 cycles) covers the second configuration word across all 32 bits within the run.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    localparam logic [1:0] SEL_LOWER_HALVES = 2'd0;
    localparam logic [1:0] SEL_UPPER_HALVES = 2'd1;
    localparam logic [1:0] SEL_START_HOLD   = 2'd2;

endpackage

// File: rtl/scl_div_regs.sv
module scl_div_regs
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] HI_RST = '0,
    parameter logic [CNT_W-1:0] LO_RST = '0,
    parameter logic [CNT_W-1:0] HOLD_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt,
    output logic [CNT_W-1:0] hold_cnt
);
    localparam int HALF = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hold;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_LOWER_HALVES: begin
                    r_d.hi[HALF-1:0] = wr_data[CNT_W-1:HALF];
                    r_d.lo[HALF-1:0] = wr_data[HALF-1:0];
                end
                SEL_UPPER_HALVES: begin
                    r_d.hi[CNT_W-1:HALF] = wr_data[CNT_W-1:HALF];
                    r_d.lo[CNT_W-1:HALF] = wr_data[HALF-1:0];
                end
                SEL_START_HOLD: r_d.hold = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.hi   <= HI_RST;
            r_q.lo   <= LO_RST;
            r_q.hold <= HOLD_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign hi_cnt   = r_q.hi;
    assign lo_cnt   = r_q.lo;
    assign hold_cnt = r_q.hold;

    a_r2_lower_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_LOWER_HALVES) |=>
            (hi_cnt[HALF-1:0] == $past(wr_data[CNT_W-1:HALF]) &&
             lo_cnt[HALF-1:0] == $past(wr_data[HALF-1:0])))
        else $error("R2 lower halves not loaded");

    a_r3_unused_select: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=>
            ($stable(hi_cnt) && $stable(lo_cnt) && $stable(hold_cnt)))
        else $error("R3 unused select changed a count");

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             first,
    output logic             mid,
    output logic             last
);
    typedef struct packed {
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.len = (load_len == '0) ? CNT_W'(1) : load_len;
            c_d.cnt = '0;
        end else if (!last) begin
            c_d.cnt = c_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.len <= CNT_W'(1);
            c_q.cnt <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign first = (c_q.cnt == '0);
    assign mid   = (c_q.cnt == (c_q.len >> 1));
    assign last  = (c_q.cnt == c_q.len - CNT_W'(1));

    a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.len != '0)
        else $error("R9 zero phase length latched");

    a_r10_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(c_q.len))
        else $error("R10 phase length changed mid-phase");

    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt < c_q.len)
        else $error("R6 phase counter overran its length");

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int SRC_HZ = 26_000_000,
    parameter int SCL_HZ = 100_000,
    parameter int CNT_W  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        start_req,
    input  logic        stop_req,
    output logic        scl_o,
    output logic        sda_hold_o,
    output logic        sda_change_o,
    output logic        sda_sample_o
);
    localparam int PRESCALE = SRC_HZ / (4 * SCL_HZ) - 1;
    localparam int HI_DEF   = (PRESCALE * 4) / 5;
    localparam int LO_DEF   = (PRESCALE * 6) / 5;
    localparam int HOLD_DEF = (SCL_HZ >= 400_000) ? (6 * (SRC_HZ / 100)) / 100_000
                                                  : (4 * (SRC_HZ / 100)) / 10_000;

    logic [CNT_W-1:0] hi_cnt, lo_cnt, hold_cnt;
    logic             ph_first, ph_mid, ph_last;
    logic             ld;
    logic [CNT_W-1:0] ld_len;

    typedef struct packed {
        phase_e phase;
    } fsm_t;

    fsm_t st_d, st_q;

    scl_div_regs #(
        .CNT_W   (CNT_W),
        .HI_RST  (CNT_W'(HI_DEF)),
        .LO_RST  (CNT_W'(LO_DEF)),
        .HOLD_RST(CNT_W'(HOLD_DEF))
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata[CNT_W-1:0]),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .hold_cnt(hold_cnt)
    );

    scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld),
        .load_len(ld_len),
        .first   (ph_first),
        .mid     (ph_mid),
        .last    (ph_last)
    );

    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_len = lo_cnt;
        unique case (st_q.phase)
            PH_IDLE: if (start_req) begin
                st_d.phase = PH_HOLD;
                ld         = 1'b1;
                ld_len     = hold_cnt;
            end
            PH_HOLD: if (ph_last) begin
                st_d.phase = PH_LOW;
                ld         = 1'b1;
                ld_len     = lo_cnt;
            end
            PH_LOW: if (ph_last) begin
                st_d.phase = PH_HIGH;
                ld         = 1'b1;
                ld_len     = hi_cnt;
            end
            PH_HIGH: if (ph_last) begin
                if (stop_req) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.phase = PH_LOW;
                    ld         = 1'b1;
                    ld_len     = lo_cnt;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.phase <= PH_IDLE;
        else        st_q <= st_d;
    end

    assign scl_o        = (st_q.phase != PH_LOW);
    assign sda_hold_o   = (st_q.phase == PH_HOLD);
    assign sda_change_o = (st_q.phase == PH_LOW) && ph_first;
    assign sda_sample_o = (st_q.phase == PH_HIGH) && ph_mid;

    a_r8_idle_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !start_req) |=> st_q.phase == PH_IDLE)
        else $error("R8 left idle without start");

    a_r7_continue_without_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HIGH && ph_last && !stop_req) |=> !scl_o)
        else $error("R7 no low phase after high without stop");

    a_r5_change_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> sda_change_o)
        else $error("R5 SDA change strobe missing at SCL fall");

    a_r6_sample_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample_o |-> (scl_o && !sda_hold_o))
        else $error("R6 sample strobe outside high phase");

endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        scl_o, sda_hold_o, sda_change_o, sda_sample_o;

    int    checks = 0;
    int    fails = 0;
    string scen = "R1";
    bit    cmp_en = 1'b0;

    // Reference model state: 0 idle, 1 hold, 2 low, 3 high
    int          mstate = 0;
    int unsigned mlen = 1;
    int unsigned mcnt = 0;
    int unsigned mhi = 12;
    int unsigned mlo = 18;
    int unsigned mhold = 15;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timing_gen #(.SRC_HZ(26_000_000), .SCL_HZ(400_000), .CNT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start_req(start_req), .stop_req(stop_req),
        .scl_o(scl_o), .sda_hold_o(sda_hold_o), .sda_change_o(sda_change_o),
        .sda_sample_o(sda_sample_o)
    );

    function automatic int unsigned eff(int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mstate = 0; mlen = 1; mcnt = 0;
            mhi = 12; mlo = 18; mhold = 15;
        end else begin
            if (mstate == 0) begin
                if (start_req) begin mstate = 1; mlen = eff(mhold); mcnt = 0; end
            end else if (mcnt == mlen - 1) begin
                if (mstate == 1)      begin mstate = 2; mlen = eff(mlo); mcnt = 0; end
                else if (mstate == 2) begin mstate = 3; mlen = eff(mhi); mcnt = 0; end
                else if (stop_req)    mstate = 0;
                else                  begin mstate = 2; mlen = eff(mlo); mcnt = 0; end
            end else begin
                mcnt++;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: begin
                        mhi = (mhi & 32'hFFFF_0000) | {16'd0, cfg_wdata[31:16]};
                        mlo = (mlo & 32'hFFFF_0000) | {16'd0, cfg_wdata[15:0]};
                    end
                    2'd1: begin
                        mhi = (mhi & 32'h0000_FFFF) | {cfg_wdata[31:16], 16'd0};
                        mlo = (mlo & 32'h0000_FFFF) | {cfg_wdata[15:0], 16'd0};
                    end
                    2'd2: mhold = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [scenario %s] %s actual=%0b expected=%0b", req, scen, nm, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R5", "scl_o", scl_o, mstate != 2);
            chk("R4", "sda_hold_o", sda_hold_o, mstate == 1);
            chk("R5", "sda_change_o", sda_change_o, mstate == 2 && mcnt == 0);
            chk("R6", "sda_sample_o", sda_sample_o, mstate == 3 && mcnt == mlen / 2);
        end
    end

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic stop_and_wait();
        stop_req = 1'b1;
        @(negedge clk);
        while (mstate != 0) @(negedge clk);
        stop_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "scl_o reset", scl_o, 1'b1);
        chk("R1", "sda_hold_o reset", sda_hold_o, 1'b0);
        chk("R1", "sda_change_o reset", sda_change_o, 1'b0);
        chk("R1", "sda_sample_o reset", sda_sample_o, 1'b0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);

        // R1: derived fast-rate defaults over several bit periods
        scen = "R1";
        pulse_start();
        repeat (100) @(negedge clk);
        stop_and_wait();

        // R2: lower halves, plus R4 start hold count
        scen = "R2";
        wr(2'd0, {16'd5, 16'd7});
        wr(2'd2, 32'd3);
        pulse_start();
        repeat (60) @(negedge clk);
        stop_and_wait();

        // R8: start while busy is ignored
        scen = "R8";
        pulse_start();
        repeat (9) @(negedge clk);
        pulse_start();
        repeat (13) @(negedge clk);
        pulse_start();
        repeat (7) @(negedge clk);
        stop_and_wait();

        // R9: zero counts give one-cycle phases
        scen = "R9";
        wr(2'd0, 32'd0);
        wr(2'd2, 32'd0);
        pulse_start();
        repeat (20) @(negedge clk);
        stop_and_wait();

        // R10: write during a phase applies from the next phase
        scen = "R10";
        wr(2'd0, {16'd6, 16'd9});
        wr(2'd2, 32'd2);
        pulse_start();
        repeat (5) @(negedge clk);
        wr(2'd0, {16'd3, 16'd4});
        repeat (40) @(negedge clk);
        stop_and_wait();

        // R7: stop held from the start ends after first high phase
        scen = "R7";
        wr(2'd0, {16'd4, 16'd5});
        stop_req = 1'b1;
        pulse_start();
        repeat (20) @(negedge clk);
        chk("R7", "scl_o idle after stop", scl_o, 1'b1);
        stop_req = 1'b0;
        pulse_start();
        repeat (33) @(negedge clk);
        stop_and_wait();

        // R3: upper halves and ignored select 3
        scen = "R3";
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, {16'd2, 16'd3});
        wr(2'd1, {16'd1, 16'd0});
        stop_req = 1'b1;
        pulse_start();
        while (mstate != 0) @(negedge clk);
        stop_req = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd1, 32'd0);
        pulse_start();
        repeat (25) @(negedge clk);
        stop_and_wait();

        summary();
        $finish;
    end
endmodule